// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block tries to free a two-wire bus that a hung target holds low. A one-cycle fault strobe from the surrounding connection logic starts it. The block first waits a settling interval with both lines left alone. It then clocks SCL at a slow fixed rate, one pulse after another, so that the hung target can shift out whatever byte it is stuck in. It ends the attempt with a STOP condition. The block watches the sampled bus lines. When SDA and SCL are both seen high while SCL is released, the pulse train ends at once and the STOP follows.

Both outputs are drive-low enables for open-drain pads, where 1 pulls the line low. A one-cycle done flag marks the end of each attempt. Timing is set by parameters: the system clock frequency, the recovery clock rate (5.5 kHz by default), the settling time (40 µs by default) and the pulse limit (16 by default). The half-period H and the settling count S are derived from these parameters.

Top module: `bus_unstick_seq`

## Requirements
- R1: After reset, `scl_lo_o`, `sda_lo_o` and `done_o` are all 0.
- R2: After an accepted `fault_i` strobe, neither line is driven for at least S cycles, where S is the settling time expressed in clock cycles and rounded up. The first drive appears no later than S+2 cycles after the strobe edge.
- R3: Every recovery pulse holds SCL low for exactly H cycles, where H = CLK_HZ/(2·PULSE_HZ). When the train runs to its limit, every SCL-released interval between pulses is also exactly H cycles.
- R4: At most MAX_PULSES SCL low pulses are generated per attempt.
- R5: `sda_lo_o` stays 0 for the whole pulse train. SDA is pulled low exactly once per attempt, and only for the STOP.
- R6: If SDA and SCL are both high while SCL is released during the train, no further pulse is generated. The number of pulses equals the number of released-SCL phases the hung target needed.
- R7: If the bus is already free when the settling interval ends, zero pulses are generated and the STOP follows directly.
- R8: The STOP proceeds in four steps, each held at least H cycles:
  - SCL is pulled low with SDA released.
  - SDA is pulled low while SCL is low.
  - SCL is released.
  - SDA is released.

  SDA only rises or falls while SCL is held low, except for that final release.
- R9: `done_o` is high for exactly one cycle per attempt. It is high in the cycle in which SDA is released at the end of the STOP.
- R10: A `fault_i` strobe that arrives while an attempt is running is ignored. No second attempt follows, and the lines stay released after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_i | input | 1 | One-cycle start strobe |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |
| scl_lo_o | output | 1 | Pull SCL low when 1 |
| sda_lo_o | output | 1 | Pull SDA low when 1 |
| done_o | output | 1 | One-cycle end-of-attempt pulse |

## Verification
The release check and the pulse limit can both end the train during the same released-SCL phase. The bench provokes this with a modelled target that lets go of SDA exactly at the sixteenth pulse, and with targets that never let go. In either case it judges that exactly sixteen pulses and a single STOP appear. A start strobe can also fall in the middle of a running attempt. The bench injects strobes at random points and judges that the pulse count is unchanged, that exactly one done pulse occurs, and that the lines stay quiet afterwards.

// File: rtl/unstick_pkg.sv
package unstick_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_LOW,
        ST_HIGH,
        ST_PRE,
        ST_SDALO,
        ST_SCLUP
    } unstick_state_e;

    typedef struct packed {
        unstick_state_e st;
        logic           scl_lo;
        logic           sda_lo;
        logic           done;
    } unstick_ctl_t;
endpackage

// File: rtl/unstick_timer.sv
module unstick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R3: phase length comes from a steady one-per-cycle countdown
    p_tick_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/unstick_pulse_cnt.sv
module unstick_pulse_cnt #(
    parameter int MAX_PULSES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = (MAX_PULSES > 2) ? $clog2(MAX_PULSES) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CW'(MAX_PULSES - 1));

    // R4: the sequencer never asks for a pulse beyond the limit
    p_no_extra_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !last_o);
endmodule

// File: rtl/bus_unstick_seq.sv
module bus_unstick_seq
    import unstick_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int PULSE_HZ   = 5_500,
    parameter int SETTLE_NS  = 40_000,
    parameter int MAX_PULSES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lo_o,
    output logic sda_lo_o,
    output logic done_o
);
    localparam int     HALF_CYC   = CLK_HZ / (2 * PULSE_HZ);
    localparam longint SETTLE_L   = (longint'(CLK_HZ) * longint'(SETTLE_NS)
                                     + 64'd999_999_999) / 64'd1_000_000_000;
    localparam int     SETTLE_CYC = (SETTLE_L < 1) ? 1 : int'(SETTLE_L);
    localparam int     TMAX       = (HALF_CYC > SETTLE_CYC) ? HALF_CYC : SETTLE_CYC;
    localparam int     TW         = $clog2(TMAX + 1);

    unstick_ctl_t  d, q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;
    logic          cnt_clr, cnt_inc, cnt_last;
    logic          bus_free;

    assign bus_free = scl_i && sda_i;

    unstick_timer #(.W(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    unstick_pulse_cnt #(.MAX_PULSES(MAX_PULSES)) u_pcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .last_o (cnt_last)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = TW'(HALF_CYC - 1);
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        unique case (q.st)
            ST_IDLE: if (fault_i) begin
                d.st     = ST_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = TW'(SETTLE_CYC - 1);
            end
            ST_SETTLE: if (tmr_exp) begin
                cnt_clr  = 1'b1;
                tmr_load = 1'b1;
                d.st     = bus_free ? ST_PRE : ST_LOW;
            end
            ST_LOW: if (tmr_exp) begin
                tmr_load = 1'b1;
                d.st     = ST_HIGH;
            end
            ST_HIGH: begin
                if (bus_free || (tmr_exp && cnt_last)) begin
                    tmr_load = 1'b1;
                    d.st     = ST_PRE;
                end else if (tmr_exp) begin
                    tmr_load = 1'b1;
                    cnt_inc  = 1'b1;
                    d.st     = ST_LOW;
                end
            end
            ST_PRE: if (tmr_exp) begin
                tmr_load = 1'b1;
                d.st     = ST_SDALO;
            end
            ST_SDALO: if (tmr_exp) begin
                tmr_load = 1'b1;
                d.st     = ST_SCLUP;
            end
            ST_SCLUP: if (tmr_exp) begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
        d.scl_lo = (d.st == ST_LOW) || (d.st == ST_PRE) || (d.st == ST_SDALO);
        d.sda_lo = (d.st == ST_SDALO) || (d.st == ST_SCLUP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, scl_lo: 1'b0, sda_lo: 1'b0, done: 1'b0};
        else        q <= d;
    end

    assign scl_lo_o = q.scl_lo;
    assign sda_lo_o = q.sda_lo;
    assign done_o   = q.done;

    p_settle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SETTLE) |-> (!scl_lo_o && !sda_lo_o));

    p_sda_free_train_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOW || q.st == ST_HIGH) |-> !sda_lo_o);

    p_release_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HIGH && bus_free) |=> (q.st == ST_PRE));

    p_free_at_settle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SETTLE && tmr_exp && bus_free) |=> (q.st == ST_PRE));

    p_sda_fall_under_scl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_lo_o) |-> (scl_lo_o && $past(scl_lo_o)));

    p_stop_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_lo_o) |-> !scl_lo_o);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && q.st != ST_SETTLE && fault_i) |=> (q.st != ST_SETTLE));
endmodule

// File: tb/tb_bus_unstick_seq.sv
module tb_bus_unstick_seq;
    localparam int CLK_HZ = 1_100_000;
    localparam int H      = 100;   // CLK_HZ / (2*5500)
    localparam int S      = 44;    // ceil(CLK_HZ * 40us)
    localparam int MAXP   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fault = 1'b0;
    logic scl_in, sda_in;
    logic scl_lo, sda_lo, done;

    int dev_n    = 0;
    int rel_seen = 0;
    int errors   = 0;
    int checks   = 0;

    always #10 clk = ~clk;

    assign scl_in = !scl_lo;
    assign sda_in = !(sda_lo || (rel_seen < dev_n));

    bus_unstick_seq #(.CLK_HZ(CLK_HZ), .MAX_PULSES(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .fault_i(fault),
        .scl_i(scl_in), .sda_i(sda_in),
        .scl_lo_o(scl_lo), .sda_lo_o(sda_lo), .done_o(done)
    );

    function automatic int exp_pulses(input int n);
        return (n > MAXP) ? MAXP : n;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_seq(input int n, input int extra_at);
        int rises = 0, lowrun = 0, highrun = 0, bad_low = 0, bad_high = 0;
        int first = 0, sda_rise = 0, sda_bad = 0, done_cnt = 0;
        int sclup_at = 0, gap = 0, busy_act = 0;
        bit p_scl = 1'b0, p_sda = 1'b0, fin = 1'b0;
        dev_n    = n;
        rel_seen = 0;
        @(negedge clk); fault = 1'b1;
        @(negedge clk); fault = 1'b0;
        for (int k = 1; k < 20000 && !fin; k++) begin
            if (first == 0 && (scl_lo || sda_lo)) first = k;
            if (scl_lo && !p_scl) begin
                rises++;
                if (rises > 1 && highrun != H) bad_high++;
                highrun = 0;
            end
            if (!scl_lo && p_scl) begin
                if (!sda_lo && lowrun != H) bad_low++;
                if (sda_lo) sclup_at = k;
                else rel_seen++;
                lowrun = 0;
            end
            if (scl_lo) lowrun++; else highrun++;
            if (sda_lo && !p_sda) begin
                sda_rise++;
                if (!scl_lo) sda_bad++;
            end
            if (!sda_lo && p_sda) begin
                if (scl_lo) sda_bad++;
                gap = k - sclup_at;
            end
            if (done) begin done_cnt++; fin = 1'b1; end
            p_scl = scl_lo;
            p_sda = sda_lo;
            fault = (k == extra_at);
            @(negedge clk);
        end
        fault = 1'b0;
        check(fin, "R9 watchdog-seq", fin, 1);
        check(first > S && first <= S + 2, "R2 settle", first, S + 1);
        check(bad_low == 0, "R3 low-phase", bad_low, 0);
        if (n > MAXP) check(bad_high == 0, "R3 high-phase", bad_high, 0);
        if (n == 0) check(rises - 1 == 0, "R7 zero-pulse", rises - 1, 0);
        else if (n > MAXP) check(rises - 1 == MAXP, "R4 limit", rises - 1, MAXP);
        else check(rises - 1 == n, "R6 early-end", rises - 1, n);
        check(sda_rise == 1, "R5 sda-once", sda_rise, 1);
        check(sda_bad == 0, "R8 stop-order", sda_bad, 0);
        check(gap >= H, "R8 stop-gap", gap, H);
        for (int k = 0; k < 30; k++) begin
            if (scl_lo || sda_lo || done) busy_act++;
            @(negedge clk);
        end
        check(busy_act == 0, extra_at > 0 ? "R10 ignored-start" : "R9 quiet-after",
              busy_act, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4313));
        repeat (3) @(negedge clk);
        check(!scl_lo, "R1 scl", scl_lo, 0);
        check(!sda_lo, "R1 sda", sda_lo, 0);
        check(!done, "R1 done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_seq(0, 0);          // R7: bus already free
        run_seq(1, 0);          // R6: releases after one pulse
        run_seq(16, 0);         // release coincides with limit
        run_seq(40, 0);         // R4: never releases
        run_seq(5, 300);        // R10: strobe mid-train
        for (int i = 0; i < 12; i++) begin
            int n = int'($urandom_range(0, 20));
            int x = ($urandom_range(0, 1) == 1) ? int'($urandom_range(2, 800)) : 0;
            run_seq(n, x);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule